// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block steps a processor's external memory bus through its cycle phases. It holds one state register that moves between idle, bus-hold grant, address phase, data phase, a suspended (backed-off) state, an emulation float state, and three programmable wait states. The three wait states are address-to-data, data-to-data and end-of-cycle recovery. The request queue upstream supplies a pending flag and the direction of the request at the head of the queue. A region decoder supplies static wait counts, one set per direction, together with two mode bits: honour the external ready/terminate pins, and overlap back-to-back reads.

The state is exported together with an address strobe, a data strobe and a hold acknowledge. Address generation and the data path follow these strobes. The direction of the access in flight is captured when its cycle starts. That direction selects every wait count and decides whether the pipelined-read shortcut applies.

Top module: `bus_cycle_fsm`

## Requirements
- R1: State codes are IDLE=0, HOLD=1, ADDR=2, DATA=3, AWAIT=4, DWAIT=5, RWAIT=6, BOFF=7, FLOAT=8. A clock edge with `rst_n` low loads FLOAT when `once_i` is high and IDLE otherwise. FLOAT persists until the next reset and drives every strobe low.
- R2: In IDLE, `hold_i` high moves to HOLD, even when a request is pending. `req_i` high with `hold_i` low moves to ADDR. HOLD returns to IDLE once `hold_i` is low. `hlda_o` is high only in HOLD.
- R3: `ads_o` is high in ADDR. `wr_i` is latched as the access direction (1 = write) on the edge that starts a cycle. From ADDR the block goes to AWAIT when that direction's address-to-data count is nonzero, and to DATA otherwise.
- R4: A wait state entered with count N lasts exactly N cycles and then moves to its successor. A count of zero skips the wait state.
- R5: `dstb_o` is high in DATA. With external ready control on, DATA repeats while `ready_i` and `bterm_i` are both low. Either of the two acknowledges the beat.
- R6: With external ready control off, every DATA cycle is acknowledged regardless of `ready_i` and `bterm_i`.
- R7: An acknowledged beat with `blast_i` low enters DWAIT when the direction's data-to-data count is nonzero, and enters DATA again otherwise.
- R8: An acknowledged beat with `blast_i` high enters RWAIT when the direction's recovery count is nonzero. Otherwise, and likewise when RWAIT ends, the block goes to HOLD if `hold_i` is high, to ADDR if `req_i` is high, and to IDLE otherwise.
- R9: `boff_i` high in ADDR, AWAIT, DATA or DWAIT moves to BOFF. BOFF persists while `boff_i` is high and then restarts the same access at ADDR, keeping its latched direction.
- R10: With pipelining on, a read's acknowledged last beat overlaps the next address phase when a read request is pending, `hold_i` is low and the read recovery count is zero. In that DATA cycle `ads_o` is also high, and the next state is AWAIT or DATA. Pipelined reads ignore `ready_i` and `bterm_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| once_i | input | 1 | Float request sampled during reset |
| req_i | input | 1 | A request is pending |
| wr_i | input | 1 | Direction of the pending request (1 = write) |
| rd_ad_i | input | CNT_W | Read address-to-data wait count |
| wr_ad_i | input | CNT_W | Write address-to-data wait count |
| rd_dd_i | input | CNT_W | Read data-to-data wait count |
| wr_dd_i | input | CNT_W | Write data-to-data wait count |
| rd_da_i | input | CNT_W | Read recovery wait count |
| wr_da_i | input | CNT_W | Write recovery wait count |
| ext_rdy_en_i | input | 1 | Honour ready/terminate pins |
| pipe_en_i | input | 1 | Enable read overlap |
| ready_i | input | 1 | External ready |
| bterm_i | input | 1 | External burst terminate |
| hold_i | input | 1 | Bus hold request |
| boff_i | input | 1 | Back-off request |
| blast_i | input | 1 | Current beat is the last |
| state_o | output | 4 | Current state code |
| hlda_o | output | 1 | Hold acknowledge |
| ads_o | output | 1 | Address phase strobe |
| dstb_o | output | 1 | Data phase strobe |

## Verification
The bench builds the block with the default 3-bit count width. Every wait length from 0 to 7 is therefore reachable, including the longest, where the counter starts at its full value. Directed sequences cover float entry, hold, waited and unwaited bursts, recovery, back-off resume with a changed `wr_i`, and the read overlap. Randomized segments then redraw all counts and both mode bits. Each segment then runs a few hundred cycles of random handshakes, with a behavioural model compared on every cycle.

// File: rtl/bus_cycle_pkg.sv
// Package: state codes and shared widths for the bus cycle sequencer.
// Assumes a 4-bit state field is read by neighbouring logic.
package bus_cycle_pkg;
    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 4'd0,
        ST_HOLD  = 4'd1,
        ST_ADDR  = 4'd2,
        ST_DATA  = 4'd3,
        ST_AWAIT = 4'd4,
        ST_DWAIT = 4'd5,
        ST_RWAIT = 4'd6,
        ST_BOFF  = 4'd7,
        ST_FLOAT = 4'd8
    } bus_state_e;
endpackage

// File: rtl/bus_wait_ctr.sv
// Wait counter: loaded with a nonzero count on entry to a wait state and
// decremented each wait cycle; reports when the current cycle is the last.
// Assumes load and dec are never high together.
module bus_wait_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Count register: load on entry, step down while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - ONE;
    end

    // Final wait cycle flag.
    always_comb last = (cnt_q == ONE);

    // R4: a wait cycle never sees an exhausted count
    p_wait_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> cnt_q != '0);
    // R4: zero counts must skip the wait state instead of loading
    p_load_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> load_val != '0);
endmodule

// File: rtl/bus_ack_qual.sv
// Beat acknowledge and count selection for the access in flight.
// Assumes dir_q holds the latched direction (1 = write).
module bus_ack_qual #(
    parameter int CNT_W = 3
) (
    input  logic             dir_q,
    input  logic             ext_rdy_en,
    input  logic             pipe_en,
    input  logic             ready,
    input  logic             bterm,
    input  logic             req,
    input  logic             hold,
    input  logic             nxt_wr,
    input  logic [CNT_W-1:0] rd_ad,
    input  logic [CNT_W-1:0] wr_ad,
    input  logic [CNT_W-1:0] rd_dd,
    input  logic [CNT_W-1:0] wr_dd,
    input  logic [CNT_W-1:0] rd_da,
    input  logic [CNT_W-1:0] wr_da,
    output logic             ack,
    output logic             pipe_ok,
    output logic [CNT_W-1:0] sel_ad,
    output logic [CNT_W-1:0] sel_dd,
    output logic [CNT_W-1:0] sel_da
);
    logic pipe_rd;

    // Pipelined reads bypass external ready control.
    always_comb pipe_rd = pipe_en && !dir_q;

    // Beat acknowledge from the pins or forced when the pins are ignored.
    always_comb ack = !ext_rdy_en || pipe_rd || ready || bterm;

    // Overlap allowed when a further read follows with no recovery.
    always_comb pipe_ok = pipe_rd && req && !hold && !nxt_wr && (rd_da == '0);

    // Per-direction wait count selection.
    always_comb begin
        sel_ad = dir_q ? wr_ad : rd_ad;
        sel_dd = dir_q ? wr_dd : rd_dd;
        sel_da = dir_q ? wr_da : rd_da;
    end
endmodule

// File: rtl/bus_next_state.sv
// Next-state decode for the bus cycle sequencer, including wait counter
// load requests, direction capture and the pipelined address overlap.
// Assumes the ack and count inputs refer to the latched direction.
module bus_next_state
    import bus_cycle_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  bus_state_e       state,
    input  logic             req,
    input  logic             nxt_wr,
    input  logic             hold,
    input  logic             boff,
    input  logic             blast,
    input  logic             ack,
    input  logic             pipe_ok,
    input  logic             cnt_last,
    input  logic [CNT_W-1:0] sel_ad,
    input  logic [CNT_W-1:0] sel_dd,
    input  logic [CNT_W-1:0] sel_da,
    input  logic [CNT_W-1:0] rd_ad,
    output bus_state_e       nxt,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             dir_load,
    output logic             dir_val,
    output logic             overlap
);
    // End-of-cycle choice shared by the last beat and the recovery wait.
    task automatic pick_after(output bus_state_e s, output logic dl);
        dl = 1'b0;
        if (hold)
            s = ST_HOLD;
        else if (req) begin
            s  = ST_ADDR;
            dl = 1'b1;
        end else
            s = ST_IDLE;
    endtask

    // Transition decode for every state.
    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = '0;
        dir_load = 1'b0;
        dir_val  = nxt_wr;
        overlap  = 1'b0;
        unique case (state)
            ST_FLOAT: nxt = ST_FLOAT;
            ST_IDLE: begin
                if (hold)
                    nxt = ST_HOLD;
                else if (req) begin
                    nxt      = ST_ADDR;
                    dir_load = 1'b1;
                end
            end
            ST_HOLD: if (!hold) nxt = ST_IDLE;
            ST_ADDR: begin
                if (boff)
                    nxt = ST_BOFF;
                else if (sel_ad != '0) begin
                    nxt      = ST_AWAIT;
                    load     = 1'b1;
                    load_val = sel_ad;
                end else
                    nxt = ST_DATA;
            end
            ST_AWAIT, ST_DWAIT: begin
                if (boff)
                    nxt = ST_BOFF;
                else if (cnt_last)
                    nxt = ST_DATA;
            end
            ST_DATA: begin
                if (boff)
                    nxt = ST_BOFF;
                else if (ack) begin
                    if (!blast) begin
                        if (sel_dd != '0) begin
                            nxt      = ST_DWAIT;
                            load     = 1'b1;
                            load_val = sel_dd;
                        end else
                            nxt = ST_DATA;
                    end else if (pipe_ok) begin
                        overlap  = 1'b1;
                        dir_load = 1'b1;
                        dir_val  = 1'b0;
                        if (rd_ad != '0) begin
                            nxt      = ST_AWAIT;
                            load     = 1'b1;
                            load_val = rd_ad;
                        end else
                            nxt = ST_DATA;
                    end else if (sel_da != '0) begin
                        nxt      = ST_RWAIT;
                        load     = 1'b1;
                        load_val = sel_da;
                    end else
                        pick_after(nxt, dir_load);
                end
            end
            ST_RWAIT: if (cnt_last) pick_after(nxt, dir_load);
            ST_BOFF: if (!boff) nxt = ST_ADDR;
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/bus_cycle_fsm.sv
// Top of the external bus cycle sequencer: state and direction registers,
// the wait counter, acknowledge qualification and next-state decode.
// Assumes region counts and mode bits are static while a cycle runs.
module bus_cycle_fsm
    import bus_cycle_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               once_i,
    input  logic               req_i,
    input  logic               wr_i,
    input  logic [CNT_W-1:0]   rd_ad_i,
    input  logic [CNT_W-1:0]   wr_ad_i,
    input  logic [CNT_W-1:0]   rd_dd_i,
    input  logic [CNT_W-1:0]   wr_dd_i,
    input  logic [CNT_W-1:0]   rd_da_i,
    input  logic [CNT_W-1:0]   wr_da_i,
    input  logic               ext_rdy_en_i,
    input  logic               pipe_en_i,
    input  logic               ready_i,
    input  logic               bterm_i,
    input  logic               hold_i,
    input  logic               boff_i,
    input  logic               blast_i,
    output logic [STATE_W-1:0] state_o,
    output logic               hlda_o,
    output logic               ads_o,
    output logic               dstb_o
);
    bus_state_e       state_q, nxt;
    logic             dir_q;
    logic             ack, pipe_ok, cnt_last;
    logic             load, dir_load, dir_val, overlap, in_wait;
    logic [CNT_W-1:0] sel_ad, sel_dd, sel_da, load_val;

    // State register; reset picks float or idle from once_i.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= once_i ? ST_FLOAT : ST_IDLE;
        else
            state_q <= nxt;
    end

    // Direction of the access in flight, captured when a cycle starts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= 1'b0;
        else if (dir_load)
            dir_q <= dir_val;
    end

    // Wait states that consume a count.
    always_comb in_wait = (state_q == ST_AWAIT) || (state_q == ST_DWAIT) ||
                          (state_q == ST_RWAIT);

    bus_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .dec      (in_wait),
        .last     (cnt_last)
    );

    bus_ack_qual #(.CNT_W(CNT_W)) u_ack (
        .dir_q      (dir_q),
        .ext_rdy_en (ext_rdy_en_i),
        .pipe_en    (pipe_en_i),
        .ready      (ready_i),
        .bterm      (bterm_i),
        .req        (req_i),
        .hold       (hold_i),
        .nxt_wr     (wr_i),
        .rd_ad      (rd_ad_i),
        .wr_ad      (wr_ad_i),
        .rd_dd      (rd_dd_i),
        .wr_dd      (wr_dd_i),
        .rd_da      (rd_da_i),
        .wr_da      (wr_da_i),
        .ack        (ack),
        .pipe_ok    (pipe_ok),
        .sel_ad     (sel_ad),
        .sel_dd     (sel_dd),
        .sel_da     (sel_da)
    );

    bus_next_state #(.CNT_W(CNT_W)) u_nxt (
        .state    (state_q),
        .req      (req_i),
        .nxt_wr   (wr_i),
        .hold     (hold_i),
        .boff     (boff_i),
        .blast    (blast_i),
        .ack      (ack),
        .pipe_ok  (pipe_ok),
        .cnt_last (cnt_last),
        .sel_ad   (sel_ad),
        .sel_dd   (sel_dd),
        .sel_da   (sel_da),
        .rd_ad    (rd_ad_i),
        .nxt      (nxt),
        .load     (load),
        .load_val (load_val),
        .dir_load (dir_load),
        .dir_val  (dir_val),
        .overlap  (overlap)
    );

    // Output strobes decoded from the state and the overlap decision.
    always_comb begin
        state_o = state_q;
        hlda_o  = (state_q == ST_HOLD);
        ads_o   = (state_q == ST_ADDR) || overlap;
        dstb_o  = (state_q == ST_DATA);
    end

    // R1: float is left only through reset
    p_float_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state_q) == ST_FLOAT) |-> state_q == ST_FLOAT);
    // R2: hold request in idle is granted on the next edge
    p_hold_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state_q) == ST_IDLE && $past(hold_i)) |-> state_q == ST_HOLD);
    // R2: hold acknowledge never coincides with a bus phase strobe
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hlda_o, ads_o || dstb_o}));
    // R5: an unacknowledged beat holds the data state
    p_ready_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state_q) == ST_DATA && $past(ext_rdy_en_i) &&
         !$past(pipe_en_i && !dir_q) && !$past(ready_i) && !$past(bterm_i) &&
         !$past(boff_i)) |-> state_q == ST_DATA);
    // R9: back-off during an access suspends it
    p_boff_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(boff_i) &&
         ($past(state_q) == ST_ADDR || $past(state_q) == ST_AWAIT ||
          $past(state_q) == ST_DATA || $past(state_q) == ST_DWAIT)) |-> state_q == ST_BOFF);
    // R9: release of back-off restarts at the address phase, same direction
    p_boff_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state_q) == ST_BOFF && !$past(boff_i)) |->
        (state_q == ST_ADDR && $stable(dir_q)));
endmodule

// File: tb/tb_bus_cycle_fsm.sv
module tb_bus_cycle_fsm;
    localparam int CLK_P = 10;
    localparam int CW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0, once = 1'b0, req = 1'b0, wr = 1'b0;
    logic [CW-1:0] rd_ad = '0, wr_ad = '0, rd_dd = '0, wr_dd = '0, rd_da = '0, wr_da = '0;
    logic ext_rdy = 1'b1, pipe = 1'b0, ready = 1'b0, bterm = 1'b0;
    logic hold = 1'b0, boff = 1'b0, blast = 1'b0;
    logic [3:0] state;
    logic hlda, ads, dstb;

    int vectors = 0, miscompares = 0;
    bit started = 0, done = 0;

    // Behavioural reference state
    int m_st = 0, m_cnt = 0;
    bit m_dir = 0;
    localparam int IDLE = 0, HOLD = 1, ADDR = 2, DATA = 3, AWAIT = 4,
                   DWAIT = 5, RWAIT = 6, BOFF = 7, FLOAT = 8;

    always #(CLK_P/2) clk = ~clk;

    bus_cycle_fsm #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .once_i(once), .req_i(req), .wr_i(wr),
        .rd_ad_i(rd_ad), .wr_ad_i(wr_ad), .rd_dd_i(rd_dd), .wr_dd_i(wr_dd),
        .rd_da_i(rd_da), .wr_da_i(wr_da), .ext_rdy_en_i(ext_rdy),
        .pipe_en_i(pipe), .ready_i(ready), .bterm_i(bterm), .hold_i(hold),
        .boff_i(boff), .blast_i(blast), .state_o(state), .hlda_o(hlda),
        .ads_o(ads), .dstb_o(dstb));

    function automatic bit m_ack();
        return !ext_rdy || (pipe && !m_dir) || ready || bterm;
    endfunction

    function automatic bit m_overlap();
        return m_st == DATA && !boff && m_ack() && blast && pipe && !m_dir &&
               req && !hold && !wr && rd_da == 0;
    endfunction

    task automatic m_finish_cycle();
        if (hold) m_st = HOLD;
        else if (req) begin m_st = ADDR; m_dir = wr; end
        else m_st = IDLE;
    endtask

    // Reference model step on each rising edge.
    always @(posedge clk) begin
        int ad, dd, da;
        started = 1;
        ad = m_dir ? wr_ad : rd_ad;
        dd = m_dir ? wr_dd : rd_dd;
        da = m_dir ? wr_da : rd_da;
        if (!rst_n) begin
            m_st = once ? FLOAT : IDLE; m_cnt = 0; m_dir = 0;
        end else begin
            case (m_st)
                IDLE: if (hold) m_st = HOLD; else if (req) begin m_st = ADDR; m_dir = wr; end
                HOLD: if (!hold) m_st = IDLE;
                ADDR: if (boff) m_st = BOFF;
                      else if (ad > 0) begin m_st = AWAIT; m_cnt = ad; end
                      else m_st = DATA;
                AWAIT, DWAIT: if (boff) m_st = BOFF;
                      else if (m_cnt == 1) m_st = DATA; else m_cnt--;
                DATA: if (boff) m_st = BOFF;
                      else if (m_ack()) begin
                          if (!blast) begin
                              if (dd > 0) begin m_st = DWAIT; m_cnt = dd; end
                          end else if (m_overlap()) begin
                              m_dir = 0;
                              if (rd_ad > 0) begin m_st = AWAIT; m_cnt = rd_ad; end
                          end else if (da > 0) begin m_st = RWAIT; m_cnt = da; end
                          else m_finish_cycle();
                      end
                RWAIT: if (m_cnt == 1) m_finish_cycle(); else m_cnt--;
                BOFF: if (!boff) m_st = ADDR;
                default: ;
            endcase
        end
    end

    function automatic string tag_of(int s);
        case (s)
            FLOAT: return "R1";
            IDLE, HOLD: return "R2";
            ADDR: return "R3";
            AWAIT: return "R4";
            DATA: return "R5";
            DWAIT: return "R7";
            RWAIT: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        bit e_ads;
        if (started && !done) begin
            e_ads = (m_st == ADDR) || m_overlap();
            vectors++;
            if (state !== m_st[3:0] || hlda !== (m_st == HOLD) ||
                ads !== e_ads || dstb !== (m_st == DATA)) begin
                miscompares++;
                $display("FAIL %s%s: state/hlda/ads/dstb act=%0d/%0b/%0b/%0b exp=%0d/%0b/%0b/%0b",
                         tag_of(m_st), m_overlap() ? " R10" : "", state, hlda, ads, dstb,
                         m_st, m_st == HOLD, e_ads, m_st == DATA);
            end
        end
    end

    task automatic cyc();
        @(negedge clk); #1;
    endtask

    task automatic expect_st(int exp, string tag);
        vectors++;
        if (state !== exp[3:0]) begin
            miscompares++;
            $display("FAIL %s: state act=%0d exp=%0d", tag, state, exp);
        end
    endtask

    task automatic expect_bit(logic act, logic exp, string tag, string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: %s act=%0b exp=%0b", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #(CLK_P * 60000);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog: act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: float entry and persistence
        once = 1; cyc(); cyc();
        rst_n = 1; req = 1; cyc(); cyc();
        expect_st(FLOAT, "R1");
        expect_bit(ads | dstb | hlda, 1'b0, "R1", "strobes");
        rst_n = 0; once = 0; req = 0; cyc();
        expect_st(IDLE, "R1");
        rst_n = 1;
        // R2: hold grant and release
        hold = 1; req = 1; cyc();
        expect_st(HOLD, "R2"); expect_bit(hlda, 1'b1, "R2", "hlda");
        hold = 0; req = 0; cyc();
        expect_st(IDLE, "R2");
        // R3/R4/R5/R7/R8: waited read burst
        rd_ad = 2; rd_dd = 1; rd_da = 0; req = 1; wr = 0; cyc();
        expect_st(ADDR, "R3"); expect_bit(ads, 1'b1, "R3", "ads");
        req = 0; cyc(); expect_st(AWAIT, "R4");
        cyc(); expect_st(AWAIT, "R4");
        cyc(); expect_st(DATA, "R4");
        cyc(); expect_st(DATA, "R5");
        ready = 1; cyc(); expect_st(DWAIT, "R7");
        ready = 0; cyc(); expect_st(DATA, "R7");
        bterm = 1; blast = 1; cyc(); expect_st(IDLE, "R8");
        bterm = 0; blast = 0;
        // R3/R8: write with recovery, direction latched at start
        wr_ad = 0; wr_da = 3; wr_dd = 0; req = 1; wr = 1; cyc();
        expect_st(ADDR, "R3");
        wr = 0; cyc(); expect_st(DATA, "R3");
        ready = 1; blast = 1; cyc(); expect_st(RWAIT, "R8");
        ready = 0; blast = 0; cyc(); cyc(); expect_st(RWAIT, "R8");
        cyc(); expect_st(ADDR, "R8");
        // R9: back-off and resume
        req = 0; boff = 1; cyc(); expect_st(BOFF, "R9");
        wr = 1; cyc(); expect_st(BOFF, "R9");
        boff = 0; cyc(); expect_st(ADDR, "R9");
        cyc(); expect_st(AWAIT, "R9");
        cyc(); cyc(); expect_st(DATA, "R9");
        ready = 1; blast = 1; wr = 0; cyc(); expect_st(IDLE, "R8");
        ready = 0; blast = 0;
        // R6: ready control off
        ext_rdy = 0; wr_da = 0; req = 1; wr = 1; cyc();
        req = 0; cyc(); expect_st(DATA, "R6");
        blast = 1; cyc(); expect_st(IDLE, "R6");
        blast = 0; ext_rdy = 1;
        // R10: pipelined reads
        pipe = 1; rd_ad = 0; rd_da = 0; req = 1; wr = 0; cyc();
        cyc(); expect_st(DATA, "R10");
        blast = 1; #1;
        expect_bit(ads && dstb, 1'b1, "R10", "ads&dstb overlap");
        cyc(); expect_st(DATA, "R10");
        req = 0; cyc(); expect_st(IDLE, "R10");
        blast = 0; pipe = 0;
        // R8: end of cycle into hold
        req = 1; wr = 0; cyc(); req = 0; cyc();
        hold = 1; ready = 1; blast = 1; cyc(); expect_st(HOLD, "R8");
        hold = 0; ready = 0; blast = 0; cyc(); expect_st(IDLE, "R2");
        // Randomized segments checked by the model
        for (int seg = 0; seg < 30; seg++) begin
            rd_ad = CW'($urandom_range(0, 7)); wr_ad = CW'($urandom_range(0, 7));
            rd_dd = CW'($urandom_range(0, 7)); wr_dd = CW'($urandom_range(0, 7));
            rd_da = CW'($urandom_range(0, 7)); wr_da = CW'($urandom_range(0, 7));
            ext_rdy = 1'($urandom_range(0, 1)); pipe = 1'($urandom_range(0, 1));
            if (seg % 5 == 0) begin
                rst_n = 0; once = ($urandom_range(0, 9) == 0); cyc(); rst_n = 1; once = 0;
            end
            for (int i = 0; i < 200; i++) begin
                req = ($urandom_range(0, 3) != 0); wr = 1'($urandom_range(0, 1));
                hold = ($urandom_range(0, 7) == 0); boff = ($urandom_range(0, 9) == 0);
                ready = 1'($urandom_range(0, 1)); bterm = ($urandom_range(0, 4) == 0);
                blast = ($urandom_range(0, 2) == 0);
                cyc();
            end
        end
        done = 1;
        summary();
        $finish;
    end
endmodule